// File: doc/BRIEF.md
# Windowed Pulse Frequency Counter

The block measures how fast a pulse train toggles by counting its edges over a fixed number of clock ticks. The host writes a window length in ticks and a control word that picks the counted edge polarity and whether one window or an unbroken run of windows is measured. When a window closes, the count is copied to a result register, a done flag goes high, and reading the result clears the flag. In continuous operation each window starts on the cycle after the previous one closes, so no edge is lost between windows.

The pulse input is asynchronous. It passes through a two-flop synchronizer, and a third flop keeps the previous synchronized level for edge detection. A small state machine has two states. ST_IDLE waits for a start command. ST_COUNT counts edges while the window timer runs. The transitions are named as follows:
- GO moves ST_IDLE to ST_COUNT.
- RESTART is a start command received in ST_COUNT. It begins a fresh window.
- HALT is a stop command. It moves ST_COUNT to ST_IDLE.
- RELOAD happens when a window closes in continuous mode. The state stays in ST_COUNT.
- FINISH happens when a window closes in single-shot mode. It moves ST_COUNT to ST_IDLE.

Top module: `win_edge_counter`

## Requirements
- R1: After reset, done is 0, busy is 0 and rd_data is 0.
- R2: A write to address 1 with bit 0 set is a start command. It opens a window whose length in ticks comes from the value last written to address 0, and busy is 1 on the cycle that follows. A length of 0 behaves as 1.
- R3: Bit 2 of the control word selects the polarity: 0 counts rising edges and 1 counts falling edges. A transition driven just after clock edge j is captured by the first synchronizer flop at edge j+1. It is counted at edge j+3.
- R4: When bit 1 of the control word is 0 (single-shot), exactly one window runs. At its close the count is latched, done rises and busy falls. No further result follows.
- R5: When bit 1 is 1 (continuous), a new window starts the cycle after each close. An edge counted at the closing edge belongs to the new window, so the windows together account for every edge.
- R6: The edge count saturates at all ones and does not wrap.
- R7: done stays high until rd_en is asserted. rd_data holds the last latched count, and done is 0 on the cycle after the read.
- R8: A write to address 1 with bit 0 clear stops an open window. It produces no result, and busy is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_in | input | 1 | Asynchronous pulse train to measure |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects window length, 1 selects control |
| wr_data | input | WIN_W (16) | Write data |
| rd_en | input | 1 | Result read strobe, clears done |
| rd_data | output | CNT_W (16) | Latched edge count |
| done | output | 1 | A result is waiting to be read |
| busy | output | 1 | A window is open |

## Verification
The bench drives three pulse patterns with changes on every cycle, and it models the synchronizer latency so that the expected count can be predicted for each window.
- A dense toggle over a long window reaches the count ceiling. It separates saturation from wraparound.
- Two irregular patterns run back to back in continuous mode. They place edges exactly on window boundaries, which exposes any edge that is lost, counted twice or credited to the wrong window.
- A run with falling polarity tells the two edge selections apart.

Further runs cover a zero window length, a stop in the middle of a window, and a result left unread.

// File: rtl/wfc_pkg.sv
package wfc_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } wfc_state_e;

    localparam logic REG_WINDOW = 1'b0;
    localparam logic REG_CTRL   = 1'b1;

    localparam int CTRL_GO   = 0;
    localparam int CTRL_CONT = 1;
    localparam int CTRL_FALL = 2;

endpackage

// File: rtl/wfc_edge_sync.sv
module wfc_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic fall_sel,
    output logic edge_hit
);
    logic [SYNC_N-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pulse_in};
            last_q <= sync_q[SYNC_N-1];
        end
    end

    always_comb begin
        if (fall_sel) edge_hit = last_q & ~sync_q[SYNC_N-1];
        else          edge_hit = ~last_q & sync_q[SYNC_N-1];
    end
endmodule

// File: rtl/wfc_window_timer.sv
module wfc_window_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [WIN_W-1:0] len,
    output logic             last
);
    logic [WIN_W-1:0] tick_q;
    logic [WIN_W:0]   tick_nxt;

    always_comb begin
        tick_nxt = {1'b0, tick_q} + {{WIN_W{1'b0}}, 1'b1};
        last     = run && (tick_nxt >= {1'b0, len});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tick_q <= '0;
        else if (restart) tick_q <= '0;
        else if (run)     tick_q <= last ? '0 : tick_nxt[WIN_W-1:0];
    end
endmodule

// File: rtl/wfc_sat_counter.sv
module wfc_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             reload_one,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   q <= '0;
        else if (reload)              q <= reload_one ? CNT_ONE : '0;
        else if (inc && q != CNT_MAX) q <= q + CNT_ONE;
    end
endmodule

// File: rtl/win_edge_counter.sv
module win_edge_counter #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [WIN_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    output logic             done,
    output logic             busy
);
    import wfc_pkg::*;

    wfc_state_e       state_q, state_d;
    logic [WIN_W-1:0] win_len_q;
    logic             cont_q, fall_q;
    logic [CNT_W-1:0] cnt_q, result_q;
    logic             done_q;

    logic ctrl_wr, start_cmd, stop_cmd;
    logic edge_hit, timer_last, win_end;
    logic cnt_inc, cnt_reload, cnt_reload_one;

    assign ctrl_wr   = wr_en && (wr_addr == REG_CTRL);
    assign start_cmd = ctrl_wr && wr_data[CTRL_GO];
    assign stop_cmd  = ctrl_wr && !wr_data[CTRL_GO];

    // host configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_len_q <= '0;
            cont_q    <= 1'b0;
            fall_q    <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == REG_WINDOW) begin
                win_len_q <= wr_data;
            end else begin
                cont_q <= wr_data[CTRL_CONT];
                fall_q <= wr_data[CTRL_FALL];
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: GO, RESTART, HALT, RELOAD, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_cmd) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (start_cmd)     state_d = ST_COUNT;
                else if (stop_cmd) state_d = ST_IDLE;
                else if (win_end)  state_d = cont_q ? ST_COUNT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        busy           = (state_q == ST_COUNT);
        win_end        = busy && timer_last && !ctrl_wr;
        cnt_inc        = busy && edge_hit;
        cnt_reload     = start_cmd || win_end;
        cnt_reload_one = win_end && cont_q && edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else if (win_end) begin
            result_q <= cnt_q;
            done_q   <= 1'b1;
        end else if (rd_en) begin
            done_q   <= 1'b0;
        end
    end

    assign rd_data = result_q;
    assign done    = done_q;

    wfc_edge_sync #(.SYNC_N(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .fall_sel (fall_q),
        .edge_hit (edge_hit)
    );

    wfc_window_timer #(.WIN_W(WIN_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (start_cmd),
        .len     (win_len_q),
        .last    (timer_last)
    );

    wfc_sat_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (cnt_reload),
        .reload_one (cnt_reload_one),
        .inc        (cnt_inc),
        .q          (cnt_q)
    );
endmodule

// File: rtl/wfc_checker.sv
module wfc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             rd_en,
    input logic             start_cmd,
    input logic             stop_cmd,
    input logic             win_end,
    input logic             cont_q,
    input logic [CNT_W-1:0] cnt_q
);
    p_start_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> busy);

    p_single_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !cont_q) |=> (!busy && done));

    p_cont_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && cont_q) |=> (busy && done));

    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !win_end && !start_cmd && !stop_cmd && cnt_q == {CNT_W{1'b1}})
        |=> (cnt_q == {CNT_W{1'b1}}));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !win_end) |=> !done);

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_en) |=> done);

    p_stop_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !busy);
endmodule

bind win_edge_counter wfc_checker #(.CNT_W(CNT_W)) u_wfc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rd_en     (rd_en),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .win_end   (win_end),
    .cont_q    (cont_q),
    .cnt_q     (cnt_q)
);

// File: tb/sim_win_edge_counter.sv
`timescale 1ns/1ps
module sim_win_edge_counter;
    localparam int CW = 8;
    localparam int WW = 16;
    localparam int CAP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_in = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [CW-1:0] rd_data;
    logic          done, busy;

    int    checks = 0;
    int    fails = 0;
    int    exp_q[$];
    string req_q[$];
    bit    mon_en = 1'b1;

    always #5 clk = ~clk;

    win_edge_counter #(.WIN_W(WW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pat(input int j, input int sel);
        case (sel)
            0:       pat = j[0];
            1:       pat = ((j * j + 3 * j) / 4) % 2 == 1;
            default: pat = (((j / 3) + (j * j) % 7) % 2) == 1;
        endcase
    endfunction

    task automatic reg_write(input logic addr, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = WW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: pops one expected result per done
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && done) begin
                int got;
                got = int'(rd_data);
                rd_en = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 R4 unexpected result", got, -1);
                end else begin
                    int e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk(got == e, r, got, e);
                end
                @(negedge clk);
                rd_en = 1'b0;
                chk(done == 1'b0, "R7 done cleared by read", int'(done), 0);
            end
        end
    end

    // driver: predicts window counts, then plays the pattern
    task automatic run_win(input int n, input bit cont, input bit fall,
                           input int m, input int sel, input string req);
        int cnt[8];
        int eff_n;
        int total;
        bit prev;
        int waited;
        repeat (4) @(negedge clk);
        eff_n = (n == 0) ? 1 : n;
        total = m * eff_n;
        prev  = pulse_in;
        for (int k = 0; k < 8; k++) cnt[k] = 0;
        for (int j = 0; j <= total - 4; j++) begin
            bit v;
            v = pat(j, sel);
            if (fall ? (prev && !v) : (!prev && v)) begin
                if ((j + 3) / eff_n < m) cnt[(j + 3) / eff_n]++;
            end
            prev = v;
        end
        for (int k = 0; k < m; k++) begin
            exp_q.push_back(cnt[k] > CAP ? CAP : cnt[k]);
            req_q.push_back(req);
        end
        reg_write(1'b0, n);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = WW'({fall, cont, 1'b1});
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        for (int j = 0; j <= total - 4; j++) begin
            if (j > 0) @(negedge clk);
            pulse_in = pat(j, sel);
        end
        waited = 0;
        while (exp_q.size() != 0 && waited < 4 * total + 100) begin
            @(negedge clk);
            waited++;
        end
        chk(exp_q.size() == 0, "R2 results arrive", exp_q.size(), 0);
        if (cont) begin
            reg_write(1'b1, 0);
            chk(busy == 1'b0, "R8 stop after continuous run", int'(busy), 0);
        end else begin
            chk(busy == 1'b0, "R4 idle after single window", int'(busy), 0);
        end
        repeat (3 * eff_n + 10) @(negedge clk);
        chk(busy == 1'b0, "R4 R8 remains idle", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        chk(rd_data == '0, "R1 result at reset", int'(rd_data), 0);
        rst_n = 1'b1;

        run_win(25, 1'b1, 1'b0, 4, 1, "R5 R3 continuous rising");
        run_win(30, 1'b1, 1'b1, 3, 2, "R5 R3 continuous falling");
        run_win(40, 1'b0, 1'b0, 1, 2, "R4 single rising");
        run_win(0, 1'b0, 1'b0, 1, 1, "R2 zero length window");
        run_win(600, 1'b0, 1'b0, 1, 0, "R6 saturation");

        // R8: stop inside a window yields no result
        pulse_in = 1'b0;
        reg_write(1'b0, 200);
        reg_write(1'b1, 3);
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R8 running before stop", int'(busy), 1);
        reg_write(1'b1, 0);
        chk(busy == 1'b0, "R8 stopped", int'(busy), 0);
        repeat (250) @(negedge clk);
        chk(done == 1'b0, "R8 no result after stop", int'(done), 0);

        // R7: done holds until read
        mon_en = 1'b0;
        reg_write(1'b0, 20);
        reg_write(1'b1, 1);
        repeat (40) @(negedge clk);
        chk(done == 1'b1, "R7 done holds unread", int'(done), 1);
        chk(rd_data == '0, "R7 result without edges", int'(rd_data), 0);
        exp_q.push_back(0);
        req_q.push_back("R7 held result read");
        mon_en = 1'b1;
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R7 held result consumed", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule